// File: doc/BRIEF.md
# CCD Line and Frame Pulse Generator

This block produces the timing pulses that move charge through a progressive-scan CCD sensor and frame the resulting video for the downstream analog front end. It runs from a master clock at twice the pixel rate. It divides that clock down to a pixel clock and advances a line position counter once per pixel period. A line-number counter advances once per line. Every drive and control pulse is decoded from these two counters at fixed positions and registered, so no output can glitch.

The counters lock to external active-low horizontal and vertical sync. A falling horizontal sync restarts the line at once. A falling vertical sync is honoured only when it is sampled near the start of a line, and it takes effect at the next line boundary. When no sync arrives, both counters free-run at their nominal lengths. A standby input parks every output at a safe level, while the pixel clock and the counters keep running.

Top module: `ccd_pulse_gen`

## Requirements
- R1: While `rstN` is low, `pixClk` is 0, `readoutN` and `subN` are 1, and every other output is 0. The line position and the line number both restart at 1.
- R2: `pixClk` toggles on every master clock edge. The line position advances on each edge where `pixClk` falls from 1 to 0 (a pixel tick). After position LINE_LEN (780 by default) it returns to 1.
- R3: A high-to-low change of `hdN` seen across two pixel ticks restarts the line at position 1 on that tick. Line numbers run from 1 to FRAME_LINES (525 by default) and then wrap to 1.
- R4: A high-to-low change of `vdN` seen at a tick whose line position is 1 to 35 makes the next line number 1. Such a change seen at any other position has no effect.
- R5: Each output holds the level decoded for position p during the pixel period that follows the tick at which the counter held p. Away from the readout hold, `vPhase[0]` is low for 35 <= p < 71, `vPhase[1]` is high for 47 <= p < 83, and `vPhase[2]` is low for 59 <= p < 95. Outside those windows the three phases rest at 1, 0 and 1.
- R6: On line 1, `readoutN` is low for 520 <= p < 576, and `vPhase[1]` is held high for 510 <= p < 586.
- R7: `subN` is low for 96 <= p < 107 on lines 1 to SUB_LINES (4 by default), and high everywhere else.
- R8: `blank` is high for p < 120 and on every line outside ACT_FIRST..ACT_LAST (14..507 by default). `clampObN` is low for 109 <= p < 119, and `clampDmN` is low for 12 <= p < 35.
- R9: `lineId` is high on odd line numbers and low on even ones.
- R10: With `wenSel` = 0, `wrEn` is high for whole lines in ACT_FIRST..ACT_LAST. With `wenSel` = 1, `wrEn` is high exactly while `readoutN` is low.
- R11: While `stbyN` is low, the next pixel tick sets `readoutN` and `subN` to 1 and clears all other line-decoded outputs. The next master edge clears the per-pixel strobes. `pixClk` and both counters keep running.
- R12: Outside standby, `hClk1`, `resetGate` and `shpN` equal `pixClk`, and `hClk2` and `shdN` equal its inverse, one master edge after each `pixClk` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the pixel rate |
| rstN | input | 1 | Asynchronous active-low reset |
| stbyN | input | 1 | Active-low standby |
| hdN | input | 1 | Horizontal sync, active low |
| vdN | input | 1 | Vertical sync, active low |
| wenSel | input | 1 | Write-enable mode: 0 = active lines, 1 = follow readout |
| pixClk | output | 1 | Pixel clock, master clock divided by 2 |
| vPhase | output | 3 | Vertical transfer phases |
| readoutN | output | 1 | Charge readout pulse, active low |
| subN | output | 1 | Substrate discharge pulse, active low |
| blank | output | 1 | Blanking |
| clampObN | output | 1 | Optical-black clamp, active low |
| clampDmN | output | 1 | Second clamp pulse, active low |
| lineId | output | 1 | Line identification (odd lines high) |
| wrEn | output | 1 | Write enable |
| hClk1 | output | 1 | Horizontal clock phase 1 strobe |
| hClk2 | output | 1 | Horizontal clock phase 2 strobe |
| resetGate | output | 1 | Reset gate strobe |
| shpN | output | 1 | Precharge sample-and-hold strobe, active low |
| shdN | output | 1 | Data sample-and-hold strobe, active low |

## Verification
The hardest case to reach is the vertical sync acceptance window. Whether a vdN fall restarts the frame depends on the hidden line position at the sampling tick, and the result only shows a full line later, as a readout pulse that does or does not appear. The bench keeps its own model of both counters. It places vdN falls exactly at positions 35 and 36 and then looks for the readout window on the following line. Random horizontal sync at irregular intervals and random vertical sync pulses then drive the counters through early restarts, wraps and the frame boundary, and every output is compared at every pixel tick.

// File: rtl/ccd_pulse_pkg.sv
package ccd_pulse_pkg;
  // Sync acceptance window (line positions 1..SYNC_WIN)
  localparam int SYNC_WIN = 35;

  // Vertical transfer phases
  localparam int V_PHASES = 3;
  localparam int V_BEG [V_PHASES] = '{35, 47, 59};
  localparam int V_END [V_PHASES] = '{71, 83, 95};
  localparam logic [V_PHASES-1:0] V_IDLE = 3'b101;
  localparam int RD_PHASE = 1;

  // Readout line and windows
  localparam int RD_LINE  = 1;
  localparam int RD_BEG   = 520;
  localparam int RD_END   = 576;
  localparam int HOLD_BEG = 510;
  localparam int HOLD_END = 586;

  // Substrate discharge window
  localparam int SUB_BEG = 96;
  localparam int SUB_END = 107;

  // Blanking and clamps
  localparam int BLK_END = 120;
  localparam int OB_BEG  = 109;
  localparam int OB_END  = 119;
  localparam int DM_BEG  = 12;
  localparam int DM_END  = 35;

  typedef struct packed {
    logic pixTick;
    logic lineStart;
    logic frameRestart;
  } tgStrobe_t;
endpackage

// File: rtl/ccd_pulse_ctrl.sv
module ccd_pulse_ctrl
  import ccd_pulse_pkg::*;
#(
  parameter int LINE_LEN = 780,
  parameter int POS_W    = $clog2(LINE_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hdN,
  input  logic             vdN,
  input  logic [POS_W-1:0] linePos,
  output logic             pixClk,
  output tgStrobe_t        stb
);
  logic phase, hdPrev, vdPrev, vdSeen;
  logic hdFall, vdFall, inWin, atEnd;

  always_comb begin
    inWin            = (linePos != '0) && (linePos <= POS_W'(SYNC_WIN));
    atEnd            = (linePos == POS_W'(LINE_LEN));
    hdFall           = phase & hdPrev & ~hdN;
    vdFall           = phase & vdPrev & ~vdN & inWin;
    stb.pixTick      = phase;
    stb.lineStart    = phase & (hdFall | atEnd);
    stb.frameRestart = stb.lineStart & vdSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= 1'b0;
      hdPrev <= 1'b1;
      vdPrev <= 1'b1;
      vdSeen <= 1'b0;
    end else begin
      phase <= ~phase;
      if (phase) begin
        hdPrev <= hdN;
        vdPrev <= vdN;
        if (stb.lineStart) vdSeen <= 1'b0;
        else if (vdFall)   vdSeen <= 1'b1;
      end
    end
  end

  assign pixClk = phase;

  // R4: a vertical sync outside the window leaves the pending flag untouched
  a_r4_late_vd_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (phase && !inWin && !stb.lineStart) |=> (vdSeen == $past(vdSeen)));

  // R4: an accepted vertical sync arms the frame restart
  a_r4_vd_armed: assert property (@(posedge clk) disable iff (!rstN)
    (vdFall && !stb.lineStart) |=> vdSeen);
endmodule

// File: rtl/ccd_pulse_dp.sv
module ccd_pulse_dp
  import ccd_pulse_pkg::*;
#(
  parameter int LINE_LEN    = 780,
  parameter int FRAME_LINES = 525,
  parameter int ACT_FIRST   = 14,
  parameter int ACT_LAST    = 507,
  parameter int SUB_LINES   = 4,
  parameter int POS_W       = $clog2(LINE_LEN + 1),
  parameter int LN_W        = $clog2(FRAME_LINES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                stbyN,
  input  logic                wenSel,
  input  logic                pixClk,
  input  tgStrobe_t           stb,
  output logic [POS_W-1:0]    linePos,
  output logic [V_PHASES-1:0] vPhase,
  output logic                readoutN,
  output logic                subN,
  output logic                blank,
  output logic                clampObN,
  output logic                clampDmN,
  output logic                lineId,
  output logic                wrEn,
  output logic                hClk1,
  output logic                hClk2,
  output logic                resetGate,
  output logic                shpN,
  output logic                shdN
);
  logic [LN_W-1:0] lineNum;
  int pos, ln;
  logic rdWin, holdWin, subWin, actLine, blankNext, obWin, dmWin;
  logic [V_PHASES-1:0] inWinV, vNext;

  // Position decode from the pre-edge counter values
  always_comb begin
    pos       = int'(linePos);
    ln        = int'(lineNum);
    rdWin     = (ln == RD_LINE) && (pos >= RD_BEG) && (pos < RD_END);
    holdWin   = (ln == RD_LINE) && (pos >= HOLD_BEG) && (pos < HOLD_END);
    subWin    = (ln <= SUB_LINES) && (pos >= SUB_BEG) && (pos < SUB_END);
    actLine   = (ln >= ACT_FIRST) && (ln <= ACT_LAST);
    blankNext = (pos < BLK_END) || !actLine;
    obWin     = (pos >= OB_BEG) && (pos < OB_END);
    dmWin     = (pos >= DM_BEG) && (pos < DM_END);
  end

  for (genvar i = 0; i < V_PHASES; i++) begin : g_vph
    assign inWinV[i] = (pos >= V_BEG[i]) && (pos < V_END[i]);
    if (i == RD_PHASE) begin : g_hold
      assign vNext[i] = holdWin ? 1'b1 : (V_IDLE[i] ^ inWinV[i]);
    end else begin : g_plain
      assign vNext[i] = V_IDLE[i] ^ inWinV[i];
    end
  end

  // Line and frame counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linePos <= POS_W'(1);
      lineNum <= LN_W'(1);
    end else if (stb.pixTick) begin
      if (stb.lineStart) begin
        linePos <= POS_W'(1);
        if (stb.frameRestart || lineNum == LN_W'(FRAME_LINES)) lineNum <= LN_W'(1);
        else                                                    lineNum <= lineNum + 1'b1;
      end else begin
        linePos <= linePos + 1'b1;
      end
    end
  end

  // Registered line-level outputs, updated on each pixel tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPhase   <= '0;
      readoutN <= 1'b1;
      subN     <= 1'b1;
      blank    <= 1'b0;
      clampObN <= 1'b0;
      clampDmN <= 1'b0;
      lineId   <= 1'b0;
      wrEn     <= 1'b0;
    end else if (stb.pixTick) begin
      if (!stbyN) begin
        vPhase   <= '0;
        readoutN <= 1'b1;
        subN     <= 1'b1;
        blank    <= 1'b0;
        clampObN <= 1'b0;
        clampDmN <= 1'b0;
        lineId   <= 1'b0;
        wrEn     <= 1'b0;
      end else begin
        vPhase   <= vNext;
        readoutN <= ~rdWin;
        subN     <= ~subWin;
        blank    <= blankNext;
        clampObN <= ~obWin;
        clampDmN <= ~dmWin;
        lineId   <= lineNum[0];
        wrEn     <= wenSel ? rdWin : actLine;
      end
    end
  end

  // Per-pixel strobes, updated on every master edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hClk1     <= 1'b0;
      hClk2     <= 1'b0;
      resetGate <= 1'b0;
      shpN      <= 1'b0;
      shdN      <= 1'b0;
    end else begin
      hClk1     <= stbyN & ~pixClk;
      hClk2     <= stbyN & pixClk;
      resetGate <= stbyN & ~pixClk;
      shpN      <= stbyN & ~pixClk;
      shdN      <= stbyN & pixClk;
    end
  end

  // R2: the position advances by one on a plain tick
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pixTick && !stb.lineStart) |=> (linePos == $past(linePos) + 1'b1));

  // R2: the position never leaves 1..LINE_LEN
  a_r2_pos_range: assert property (@(posedge clk) disable iff (!rstN)
    (linePos != '0) && (linePos <= POS_W'(LINE_LEN)));

  // R3: a line start puts the position back to 1
  a_r3_restart: assert property (@(posedge clk) disable iff (!rstN)
    stb.lineStart |=> (linePos == POS_W'(1)));

  // R3: the line number stays within 1..FRAME_LINES
  a_r3_line_range: assert property (@(posedge clk) disable iff (!rstN)
    (lineNum != '0) && (lineNum <= LN_W'(FRAME_LINES)));

  // R4: an accepted vertical sync makes the next line number 1
  a_r4_frame: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameRestart |=> (lineNum == LN_W'(1)));

  // R6: the readout pulse only occurs while the held phase is high
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !readoutN |-> vPhase[RD_PHASE]);

  // R10: in readout-follow mode the write enable mirrors the readout pulse
  a_r10_wen_follow: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.pixTick) && $past(wenSel)) |-> (wrEn == !readoutN));

  // R11: standby parks the line-level outputs
  a_r11_standby: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.pixTick) && !$past(stbyN)) |->
      (readoutN && subN && vPhase == '0 && !blank && !wrEn && !lineId));
endmodule

// File: rtl/ccd_pulse_gen.sv
module ccd_pulse_gen
  import ccd_pulse_pkg::*;
#(
  parameter int LINE_LEN    = 780,
  parameter int FRAME_LINES = 525,
  parameter int ACT_FIRST   = 14,
  parameter int ACT_LAST    = 507,
  parameter int SUB_LINES   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                stbyN,
  input  logic                hdN,
  input  logic                vdN,
  input  logic                wenSel,
  output logic                pixClk,
  output logic [V_PHASES-1:0] vPhase,
  output logic                readoutN,
  output logic                subN,
  output logic                blank,
  output logic                clampObN,
  output logic                clampDmN,
  output logic                lineId,
  output logic                wrEn,
  output logic                hClk1,
  output logic                hClk2,
  output logic                resetGate,
  output logic                shpN,
  output logic                shdN
);
  localparam int POS_W = $clog2(LINE_LEN + 1);
  localparam int LN_W  = $clog2(FRAME_LINES + 1);

  tgStrobe_t        stb;
  logic [POS_W-1:0] linePos;

  ccd_pulse_ctrl #(.LINE_LEN(LINE_LEN), .POS_W(POS_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hdN     (hdN),
    .vdN     (vdN),
    .linePos (linePos),
    .pixClk  (pixClk),
    .stb     (stb)
  );

  ccd_pulse_dp #(
    .LINE_LEN    (LINE_LEN),
    .FRAME_LINES (FRAME_LINES),
    .ACT_FIRST   (ACT_FIRST),
    .ACT_LAST    (ACT_LAST),
    .SUB_LINES   (SUB_LINES),
    .POS_W       (POS_W),
    .LN_W        (LN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stbyN     (stbyN),
    .wenSel    (wenSel),
    .pixClk    (pixClk),
    .stb       (stb),
    .linePos   (linePos),
    .vPhase    (vPhase),
    .readoutN  (readoutN),
    .subN      (subN),
    .blank     (blank),
    .clampObN  (clampObN),
    .clampDmN  (clampDmN),
    .lineId    (lineId),
    .wrEn      (wrEn),
    .hClk1     (hClk1),
    .hClk2     (hClk2),
    .resetGate (resetGate),
    .shpN      (shpN),
    .shdN      (shdN)
  );
endmodule

// File: tb/ccd_pulse_gen_bench.sv
module ccd_pulse_gen_bench;
  localparam int LL = 780;
  localparam int FL = 32;
  localparam int AF = 14;
  localparam int AL = 28;
  localparam int SL = 4;

  logic clk = 1'b0;
  logic rstN, stbyN, hdN, vdN, wenSel;
  logic pixClk, readoutN, subN, blank, clampObN, clampDmN, lineId, wrEn;
  logic hClk1, hClk2, resetGate, shpN, shdN;
  logic [2:0] vPhase;

  int checks = 0;
  int errors = 0;
  int mPos, mLine;
  logic mHdPrev, mVdPrev, mVdSeen;

  always #5 clk = ~clk;

  ccd_pulse_gen #(.LINE_LEN(LL), .FRAME_LINES(FL), .ACT_FIRST(AF),
                  .ACT_LAST(AL), .SUB_LINES(SL)) u_ccd_pulse_gen (
    .clk(clk), .rstN(rstN), .stbyN(stbyN), .hdN(hdN), .vdN(vdN), .wenSel(wenSel),
    .pixClk(pixClk), .vPhase(vPhase), .readoutN(readoutN), .subN(subN),
    .blank(blank), .clampObN(clampObN), .clampDmN(clampDmN), .lineId(lineId),
    .wrEn(wrEn), .hClk1(hClk1), .hClk2(hClk2), .resetGate(resetGate),
    .shpN(shpN), .shdN(shdN)
  );

  task automatic chk(input string tag, input logic [9:0] a, input logic [9:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, a, e);
    end
  endtask

  // Expected packed {vPhase[2:0], readoutN, subN, blank, clampObN, clampDmN, lineId, wrEn}
  function automatic logic [9:0] expOut(int p, int ln, logic sb, logic wm);
    logic [2:0] v;
    logic rd, act;
    if (!sb) return 10'b000_1_1_0_0_0_0_0;
    rd   = (ln == 1) && (p >= 520) && (p < 576);
    v[0] = !((p >= 35) && (p < 71));
    v[1] = ((p >= 47) && (p < 83)) || ((ln == 1) && (p >= 510) && (p < 586));
    v[2] = !((p >= 59) && (p < 95));
    act  = (ln >= AF) && (ln <= AL);
    return {v, !rd, !((ln <= SL) && (p >= 96) && (p < 107)), (p < 120) || !act,
            !((p >= 109) && (p < 119)), !((p >= 12) && (p < 35)), (ln % 2) == 1,
            wm ? rd : act};
  endfunction

  function automatic logic [9:0] actOut();
    return {vPhase, readoutN, subN, blank, clampObN, clampDmN, lineId, wrEn};
  endfunction

  // Advance one pixel tick, update the model, compare every output
  task automatic nextTick();
    logic [9:0] e, a;
    logic sb, hf, vf, ls;
    @(negedge clk);
    while (pixClk !== 1'b1) @(negedge clk);
    sb = stbyN;
    chk("R12 strobes high phase", {5'b0, hClk1, hClk2, resetGate, shpN, shdN},
        {5'b0, sb, 1'b0, sb, sb, 1'b0});
    e  = expOut(mPos, mLine, sb, wenSel);
    hf = mHdPrev && !hdN;
    vf = mVdPrev && !vdN && (mPos >= 1) && (mPos <= 35);
    ls = hf || (mPos == LL);
    if (ls) begin
      mLine   = mVdSeen ? 1 : ((mLine == FL) ? 1 : mLine + 1);
      mVdSeen = 1'b0;
    end else if (vf) mVdSeen = 1'b1;
    mPos    = ls ? 1 : mPos + 1;
    mHdPrev = hdN;
    mVdPrev = vdN;
    @(negedge clk);
    a = actOut();
    chk("R2 pixClk low after tick", {9'b0, pixClk}, 10'b0);
    chk("R12 strobes low phase", {5'b0, hClk1, hClk2, resetGate, shpN, shdN},
        {5'b0, 1'b0, sb, 1'b0, 1'b0, sb});
    if (!sb) chk("R11 standby levels", a, e);
    else begin
      chk("R5 vertical phases", {7'b0, a[9:7]}, {7'b0, e[9:7]});
      chk("R6 readout", {9'b0, a[6]}, {9'b0, e[6]});
      chk("R7 substrate", {9'b0, a[5]}, {9'b0, e[5]});
      chk("R8 blank and clamps", {7'b0, a[4:2]}, {7'b0, e[4:2]});
      chk("R9 line id", {9'b0, a[1]}, {9'b0, e[1]});
      chk("R10 write enable", {9'b0, a[0]}, {9'b0, e[0]});
    end
  endtask

  task automatic runUntil(input int p);
    while (mPos != p) nextTick();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rdCount;
    void'($urandom(32'd20240611));
    rstN = 1'b0; stbyN = 1'b1; hdN = 1'b1; vdN = 1'b1; wenSel = 1'b0;
    mPos = 1; mLine = 1; mHdPrev = 1'b1; mVdPrev = 1'b1; mVdSeen = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", actOut(), 10'b000_1_1_0_0_0_0_0);
    chk("R1 reset pixClk and strobes", {4'b0, pixClk, hClk1, hClk2, resetGate, shpN, shdN}, 10'b0);
    rstN = 1'b1;

    // Free run past one whole frame: readout seen on line 1 of both frames (R3 wrap)
    rdCount = 0;
    for (int k = 0; k < FL * LL + 600; k++) begin
      if (k == FL * LL / 2) wenSel = 1'b1;
      nextTick();
      if (!readoutN) rdCount++;
    end
    chk("R3 frame wrap gives two readouts", 10'(rdCount), 10'd112);
    wenSel = 1'b0;

    // R4: vertical sync at the last window position is accepted
    runUntil(35);
    vdN = 1'b0;
    repeat (3) nextTick();
    vdN = 1'b1;
    runUntil(LL); nextTick();
    runUntil(530); nextTick();
    chk("R4 vd at position 35 accepted", {9'b0, readoutN}, 10'b0);
    // R4: vertical sync one position late is ignored
    runUntil(36);
    vdN = 1'b0;
    repeat (3) nextTick();
    vdN = 1'b1;
    runUntil(LL); nextTick();
    runUntil(530); nextTick();
    chk("R4 vd at position 36 ignored", {9'b0, readoutN}, 10'b1);

    // R3: horizontal sync mid-line restarts the position
    runUntil(400);
    hdN = 1'b0;
    nextTick();
    nextTick();
    hdN = 1'b1;
    runUntil(40); nextTick();
    chk("R3 hd restart phases at position 40", {7'b0, vPhase}, 10'b100);

    // R11: standby parks outputs, counters keep running
    stbyN = 1'b0;
    nextTick();
    chk("R11 standby forced", {readoutN, subN, vPhase, blank, wrEn, lineId, clampObN, clampDmN},
        10'b11_000_0_0_0_0_0);
    repeat (300) nextTick();
    stbyN = 1'b1;
    repeat (200) nextTick();

    // Random sync at irregular intervals, random vertical sync, standby and mode
    for (int s = 0; s < 40; s++) begin
      int gap, hw, vdAt;
      gap    = 30 + int'($urandom % 871);
      hw     = 1 + int'($urandom % 5);
      vdAt   = (($urandom % 3) == 0) ? int'($urandom % gap) : -10;
      wenSel = $urandom % 2;
      stbyN  = (($urandom % 8) != 0);
      for (int t = 0; t < gap; t++) begin
        if (t == vdAt) vdN = 1'b0;
        if (t == vdAt + 3) vdN = 1'b1;
        if (t == gap - hw) hdN = 1'b0;
        nextTick();
      end
      hdN = 1'b1;
      vdN = 1'b1;
    end
    stbyN = 1'b1;
    repeat (100) nextTick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule